// File: doc/BRIEF.md
# Master Serial Result Transmitter

This block sends an 18-bit conversion result to a host over a three-wire serial link and drives the link's clock itself. It sits beside a successive-approximation conversion engine. The engine reports when a conversion begins and when it finishes, and at the finish it hands over the result. The block then drives a serial clock, a data line that carries the most significant bit first, a frame signal that marks when the data line is valid, and a busy flag for the host.

Two read schedules are selectable. In read-after-convert, the result is shifted out as soon as the conversion finishes, and busy stays high until the last bit has gone. In this schedule a two-bit divider slows the serial clock for slow hosts. In read-during-convert, each result is stored when its conversion finishes and is shifted out at full speed while the next conversion runs. Busy then covers only the conversion. The serial clock and the frame signal can each be inverted.

Top module: `resultSerializer`

## Requirements
- R1: After reset, raw SCLK and raw SYNC are low, SDOUT is 0 and BUSY is 0.
- R2: A transfer carries exactly 18 bits, most significant first. SDOUT holds one bit per SCLK pulse, and there are exactly 18 pulses.
- R3: SDOUT changes only at a falling SCLK edge. Each bit is steady through its whole low phase and its whole high phase.
- R4: `sclkInvert` = 1 inverts SCLK and `syncInvert` = 1 inverts SYNC, at the idle level as well as during a transfer. Raw SYNC high means the data line is valid.
- R5: Raw SYNC is high for exactly 36·H clocks per transfer, where H is the SCLK half-period. Raw SCLK is low whenever SYNC is idle.
- R6: With `readDuring` = 0, raw SYNC is high in the first cycle after the edge that samples `convDone`. BUSY stays high through the transfer and falls at the same edge as SYNC.
- R7: With `readDuring` = 0, the half-period H is 2^`clkDiv` clocks, giving 1, 2, 4 or 8 clocks.
- R8: BUSY is high in the cycle after the edge that samples `convStart`.
- R9: With `readDuring` = 1, the edge that samples `convDone` clears BUSY, and the result is stored for later.
- R10: With `readDuring` = 1, a transfer begins one clock after the edge that samples `convStart`, with raw SYNC high from the second cycle after the pulse. No transfer follows the first `convStart` after reset.
- R11: With `readDuring` = 1, H is 1 clock whatever the value of `clkDiv`.
- R12: A `convDone` that arrives during a transfer does not alter the bits being sent. Its result is the one sent on the next `convStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | One-cycle pulse: a conversion begins |
| convDone | input | 1 | One-cycle pulse: a conversion finished, `convResult` is valid |
| convResult | input | 18 | Conversion result |
| readDuring | input | 1 | 1 = read-during-convert, 0 = read-after-convert |
| sclkInvert | input | 1 | Inverts the SCLK output |
| syncInvert | input | 1 | Inverts the SYNC output |
| clkDiv | input | 2 | SCLK divider select, used in read-after-convert only |
| sclkOut | output | 1 | Serial clock |
| sdataOut | output | 1 | Serial data, most significant bit first |
| syncOut | output | 1 | Frame signal: serial data valid |
| busyOut | output | 1 | Conversion, or read-after-convert transfer, in progress |

## Verification
The bench drives inputs at falling clock edges and samples at falling edges. The first falling edge after a pulse is therefore the first cycle that shows the registered response. BUSY is due there after `convStart`. SYNC is due there after `convDone` in read-after-convert, and at the next falling edge after `convStart` in read-during-convert. The capture task counts the cycles in which SYNC is active and compares the count with 36·H, where H is derived from the mode and the divider. It takes a bit at each rise of SCLK and requires that bit to hold through the high phase. Once SYNC falls, the task checks BUSY in that same sample, so a one-cycle slip in either signal is reported.

// File: rtl/rsPkg.sv
package rsPkg;
  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic loadDirect;   // start a transfer with the incoming result
    logic loadHold;     // start a transfer with the stored result
    logic shiftNext;    // advance to the next bit at a falling SCLK edge
    logic captureHold;  // store the incoming result
  } rsStrobeT;
endpackage

// File: rtl/rsControl.sv
module rsControl
  import rsPkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DIV_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             convDone,
  input  logic             readDuring,
  input  logic [DIV_W-1:0] clkDiv,
  output rsStrobeT         strobe,
  output logic             sclkRaw,
  output logic             syncRaw,
  output logic             busy,
  output logic             txRac
);
  localparam int MAX_SHIFT = (1 << DIV_W) - 1;
  localparam int HALF_MAX  = 1 << MAX_SHIFT;
  localparam int CNT_W     = $clog2(HALF_MAX) + 1;
  localparam int BIT_W     = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic             txActive;
  logic             startPending;
  logic             haveResult;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] halfLen;
  logic [BIT_W-1:0] bitCnt;

  logic             halfEnd;
  logic             lastFall;
  logic             startReq;
  logic [CNT_W-1:0] newHalf;

  always_comb begin
    halfEnd  = txActive && (halfCnt == halfLen - CNT_W'(1));
    lastFall = halfEnd && sclkRaw && (bitCnt == LAST_BIT);
    startReq = convStart && readDuring && haveResult && !txActive && !startPending;
    newHalf  = readDuring ? CNT_W'(1) : (CNT_W'(1) << clkDiv);

    strobe.loadDirect  = convDone && !readDuring && !txActive && !startPending;
    strobe.loadHold    = startPending;
    strobe.shiftNext   = halfEnd && sclkRaw && !lastFall;
    strobe.captureHold = convDone;
  end

  // Bit and phase sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive <= 1'b0;
      sclkRaw  <= 1'b0;
      halfCnt  <= '0;
      halfLen  <= CNT_W'(1);
      bitCnt   <= '0;
      txRac    <= 1'b0;
    end else if (strobe.loadDirect || strobe.loadHold) begin
      txActive <= 1'b1;
      sclkRaw  <= 1'b0;
      halfCnt  <= '0;
      halfLen  <= newHalf;
      bitCnt   <= '0;
      txRac    <= strobe.loadDirect;
    end else if (txActive) begin
      if (halfEnd) begin
        halfCnt <= '0;
        sclkRaw <= ~sclkRaw;
        if (sclkRaw) begin
          if (bitCnt == LAST_BIT) txActive <= 1'b0;
          else                    bitCnt   <= bitCnt + BIT_W'(1);
        end
      end else begin
        halfCnt <= halfCnt + CNT_W'(1);
      end
    end
  end

  // Schedule bookkeeping and the busy flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPending <= 1'b0;
      haveResult   <= 1'b0;
      busy         <= 1'b0;
    end else begin
      startPending <= startReq;

      if (convDone && (readDuring || txActive || startPending)) haveResult <= 1'b1;
      else if (strobe.loadHold)                                 haveResult <= 1'b0;

      if (convStart)                  busy <= 1'b1;
      else if (convDone && readDuring) busy <= 1'b0;
      else if (lastFall && txRac)     busy <= 1'b0;
    end
  end

  assign syncRaw = txActive;
endmodule

// File: rtl/rsDatapath.sv
module rsDatapath
  import rsPkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobeT          strobe,
  input  logic              active,
  input  logic [DATA_W-1:0] dataIn,
  output logic              serialBit
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (strobe.captureHold) holdReg <= dataIn;
      if (strobe.loadDirect)      shiftReg <= dataIn;
      else if (strobe.loadHold)   shiftReg <= holdReg;
      else if (strobe.shiftNext)  shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign serialBit = active & shiftReg[DATA_W-1];
endmodule

// File: rtl/resultSerializer.sv
module resultSerializer
  import rsPkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  input  logic              readDuring,
  input  logic              sclkInvert,
  input  logic              syncInvert,
  input  logic [DIV_W-1:0]  clkDiv,
  output logic              sclkOut,
  output logic              sdataOut,
  output logic              syncOut,
  output logic              busyOut
);
  rsStrobeT strobe;
  logic     sclkRaw;
  logic     syncRaw;
  logic     txRac;

  rsControl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .readDuring(readDuring), .clkDiv(clkDiv), .strobe(strobe),
    .sclkRaw(sclkRaw), .syncRaw(syncRaw), .busy(busyOut), .txRac(txRac)
  );

  rsDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .active(syncRaw),
    .dataIn(convResult), .serialBit(sdataOut)
  );

  assign sclkOut = sclkRaw ^ sclkInvert;
  assign syncOut = syncRaw ^ syncInvert;
endmodule

// File: rtl/rsChecker.sv
module rsChecker (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic sclkRaw,
  input logic syncRaw,
  input logic sdataOut,
  input logic busyOut,
  input logic txRac
);
  // R5: serial clock rests low outside a frame
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !syncRaw |-> !sclkRaw);

  // R3: data holds across a high phase
  a_r3_data_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclkRaw && $past(sclkRaw)) |-> $stable(sdataOut));

  // R6: busy covers a read-after-convert transfer
  a_r6_busy_covers_rac: assert property (@(posedge clk) disable iff (!rstN)
    (syncRaw && txRac) |-> busyOut);

  // R11: single-clock half period in read-during-convert
  a_r11_rdc_fast_clock: assert property (@(posedge clk) disable iff (!rstN)
    (syncRaw && !txRac && sclkRaw) |=> !sclkRaw);

  // R8: busy follows a conversion start
  a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> busyOut);
endmodule

bind resultSerializer rsChecker uChk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .sclkRaw(sclkRaw),
  .syncRaw(syncRaw), .sdataOut(sdataOut), .busyOut(busyOut), .txRac(txRac)
);

// File: tb/test_resultSerializer.sv
module test_resultSerializer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStart = 1'b0;
  logic        convDone = 1'b0;
  logic [17:0] convResult = '0;
  logic        readDuring = 1'b0;
  logic        sclkInvert = 1'b0;
  logic        syncInvert = 1'b0;
  logic [1:0]  clkDiv = 2'd0;
  logic        sclkOut, sdataOut, syncOut, busyOut;

  int total = 0;
  int bad = 0;

  resultSerializer i_resultSerializer (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .convResult(convResult), .readDuring(readDuring), .sclkInvert(sclkInvert),
    .syncInvert(syncInvert), .clkDiv(clkDiv), .sclkOut(sclkOut),
    .sdataOut(sdataOut), .syncOut(syncOut), .busyOut(busyOut)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; convStart = 1'b0; convDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk); convStart = 1'b1;
    @(negedge clk); convStart = 1'b0;
  endtask

  task automatic pulseDone(input logic [17:0] val);
    @(negedge clk); convDone = 1'b1; convResult = val;
    @(negedge clk); convDone = 1'b0;
  endtask

  // Called at a falling edge where SYNC is expected active; returns at the first inactive sample.
  task automatic captureFrame(input int injectAt, input logic [17:0] injectVal,
                              input bit needBusy, output logic [17:0] word,
                              output int nBits, output int nCycles,
                              output int unstable, output int busyBad);
    logic prevS = 1'b0;
    logic held = 1'b0;
    logic s, y;
    word = '0; nBits = 0; nCycles = 0; unstable = 0; busyBad = 0;
    for (int guard = 0; guard < 2000; guard++) begin
      s = sclkOut ^ sclkInvert;
      y = syncOut ^ syncInvert;
      if (convDone) convDone = 1'b0;
      if (!y) break;
      nCycles++;
      if (needBusy && !busyOut) busyBad++;
      if (s && !prevS) begin
        word = {word[16:0], sdataOut};
        nBits++;
        held = sdataOut;
      end else if (s && sdataOut != held) begin
        unstable++;
      end
      prevS = s;
      if (nCycles == injectAt) begin
        convDone = 1'b1; convResult = injectVal;
      end
      @(negedge clk);
    end
  endtask

  task automatic racFrame(input logic [1:0] div, input logic [17:0] val, input string tag);
    logic [17:0] w; int nb, nc, us, bb;
    int half = 1 << div;
    readDuring = 1'b0; clkDiv = div;
    pulseStart();
    check(busyOut == 1'b1, {"R8 ", tag}, busyOut, 1);
    repeat (5) @(negedge clk);
    pulseDone(val);
    check((syncOut ^ syncInvert) == 1'b1, {"R6 sync due ", tag}, syncOut, !syncInvert);
    captureFrame(-1, '0, 1'b1, w, nb, nc, us, bb);
    check(w == val, {"R2 word ", tag}, w, val);
    check(nb == 18, {"R2 pulses ", tag}, nb, 18);
    check(us == 0, {"R3 steady ", tag}, us, 0);
    check(nc == 36 * half, {"R5 R7 window ", tag}, nc, 36 * half);
    check(bb == 0, {"R6 busy held ", tag}, bb, 0);
    check(busyOut == 1'b0, {"R6 busy falls ", tag}, busyOut, 0);
    check((sclkOut ^ sclkInvert) == 1'b0, {"R5 sclk idle ", tag}, sclkOut, sclkInvert);
  endtask

  task automatic testReset();
    applyReset();
    check(sclkOut == 1'b0, "R1 sclk", sclkOut, 0);
    check(syncOut == 1'b0, "R1 sync", syncOut, 0);
    check(sdataOut == 1'b0, "R1 sdata", sdataOut, 0);
    check(busyOut == 1'b0, "R1 busy", busyOut, 0);
  endtask

  task automatic testInvert();
    sclkInvert = 1'b1; syncInvert = 1'b1;
    @(negedge clk);
    check(sclkOut == 1'b1, "R4 sclk idle inverted", sclkOut, 1);
    check(syncOut == 1'b1, "R4 sync idle inverted", syncOut, 1);
    racFrame(2'd1, 18'h15A5A, "R4 inverted");
    sclkInvert = 1'b0; syncInvert = 1'b0;
  endtask

  task automatic testRdc();
    logic [17:0] w; int nb, nc, us, bb;
    applyReset();
    readDuring = 1'b1; clkDiv = 2'd3;
    pulseStart();
    for (int i = 0; i < 40; i++) begin
      if (syncOut) break;
      @(negedge clk);
    end
    check(syncOut == 1'b0, "R10 no frame after first start", syncOut, 0);
    check(busyOut == 1'b1, "R8 busy rdc", busyOut, 1);
    pulseDone(18'h3C00F);
    check(busyOut == 1'b0, "R9 busy cleared by done", busyOut, 0);
    pulseStart();
    check(syncOut == 1'b0, "R10 one clock gap", syncOut, 0);
    @(negedge clk);
    check(syncOut == 1'b1, "R10 frame begins", syncOut, 1);
    captureFrame(-1, '0, 1'b0, w, nb, nc, us, bb);
    check(w == 18'h3C00F, "R9 R10 stored word", w, 18'h3C00F);
    check(nc == 36, "R11 divider ignored", nc, 36);
    check(us == 0, "R3 steady rdc", us, 0);
  endtask

  task automatic testHold();
    logic [17:0] w; int nb, nc, us, bb;
    pulseDone(18'h0B7E1);
    pulseStart();
    @(negedge clk);
    captureFrame(10, 18'h2D2D2, 1'b0, w, nb, nc, us, bb);
    check(w == 18'h0B7E1, "R12 frame undisturbed", w, 18'h0B7E1);
    check(nb == 18, "R12 pulse count", nb, 18);
    pulseStart();
    @(negedge clk);
    captureFrame(-1, '0, 1'b0, w, nb, nc, us, bb);
    check(w == 18'h2D2D2, "R12 held result sent next", w, 18'h2D2D2);
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    racFrame(2'd0, 18'h2A5C3, "div0");
    racFrame(2'd2, 18'h10001, "div2");
    racFrame(2'd3, 18'h3FFFE, "div3");
    testInvert();
    testRdc();
    testHold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule